// File: doc/BRIEF.md
# Strap-latched frequency selector

This block chooses the operating frequency code of a clock generator and the ratio between its CPU clock and its PCI clock. Four frequency straps and one mode strap are sampled once, on the first reference clock edge after reset is released. After that, the pins may carry clock outputs and their levels no longer matter. A configuration byte chooses whether the strapped code or a code written by software is used. The same byte also drives the all-outputs-high-impedance control and the spread-spectrum controls.

The block models frequency as an integer divider on a fast reference clock. A code selects the length of each CPU clock phase, and the PCI clock is the CPU clock divided by 2, 3 or 4. A newly requested code takes effect only where a PCI period ends, which is also where a CPU period ends. Because of this, no output pulse is ever shortened when the frequency is switched.

Top module: `fsel_top`

## Requirements
- R1: While reset is asserted, `cpu_clk_o` and `pci_clk_o` are 0, and `outputs_hiz_o`, `spread_en_o` and `spread_kind_o` are 0.
- R2: `strap_fs_i` and `strap_mode_i` are captured on the first rising edge of `clk_ref` after `rst_n` goes high. The captured values then hold, whatever the pins do, until the next reset.
- R3: `pin2_is_stop_o` is 1 when the captured mode strap is 0 (the pin serves as the PCI stop input). It is 0 when the captured mode strap is 1 (the pin serves as a reference output).
- R4: When `cfg_sel_i[3]` is 0, the requested code is the captured strap code. When it is 1, the requested code is {`cfg_sel_i[2]`, `cfg_sel_i[6]`, `cfg_sel_i[5]`, `cfg_sel_i[4]`}, most significant bit first. Once one full PCI period has passed, `freq_code_o` shows the requested code.
- R5: `pci_ratio_o` gives the PCI divide ratio of `freq_code_o` as a binary number. It is 2 for codes 1111, 1110, 1101, 0111, 0110 and 0101. It is 4 for codes 0001 and 0000. It is 3 for every other code.
- R6: Both clocks stay low until the straps are captured. After that, every high phase and every low phase of `cpu_clk_o` lasts HALF_BASE + code cycles of `clk_ref`, where code is the active code. `pci_clk_o` rises only together with a rise of `cpu_clk_o`. It stays high for ceil(ratio/2) CPU periods, and each PCI period spans ratio CPU periods.
- R7: `freq_code_o` changes only in the cycle where `pci_clk_o` rises. Each CPU clock phase runs its full length under the code that was active when the phase began.
- R8: On the rising edge after a value is applied to `cfg_sel_i`, `outputs_hiz_o` takes bit 0 of it and `spread_en_o` takes bit 1 of it.
- R9: `spread_kind_o` is 0 for a 0.25% centre spread, 1 for a 0.5% centre spread and 2 for a 0.5% down spread. When `spread_center_i` is 0, the value is 2. Otherwise `cfg_sel_i[7]` selects 1 (bit set) or 0. The output is registered on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock that all dividers count |
| rst_n | input | 1 | Active-low reset; its release triggers the strap capture |
| strap_fs_i | input | 4 | Frequency strap pins, sampled once |
| strap_mode_i | input | 1 | Mode strap pin, sampled once |
| cfg_sel_i | input | 8 | Frequency and spread configuration byte |
| spread_center_i | input | 1 | 0 forces down spread; 1 allows a centre spread |
| freq_code_o | output | 4 | Active frequency code |
| pci_ratio_o | output | 3 | PCI divide ratio of the active code (2, 3 or 4) |
| cpu_clk_o | output | 1 | Modelled CPU clock |
| pci_clk_o | output | 1 | Modelled PCI clock |
| outputs_hiz_o | output | 1 | Request to place all clock outputs in high impedance |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_kind_o | output | 2 | Spread type code |
| pin2_is_stop_o | output | 1 | Dual-function pin acts as the PCI stop input |

## Verification
The assertions check on every cycle several properties. The captured straps never move between resets. The active code changes only on a PCI rising edge. A PCI edge always coincides with a CPU rise. The phase counter and the PCI cycle index stay inside their ranges. A cleared centre-spread input always yields the down-spread code.

Other properties can only be shown by the bench's scenarios. These are the source selection and bit gathering of the software code, the full mapping from code to divide ratio, and the exact phase lengths measured across a run of random and directed code switches. A second reset with different strap levels shows that a new capture takes place.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int FS_W    = 4;
    localparam int RATIO_W = 3;

    typedef enum logic [1:0] {
        SPR_CTR_QTR   = 2'd0,
        SPR_CTR_HALF  = 2'd1,
        SPR_DOWN_HALF = 2'd2
    } spread_kind_e;

    // PCI divide ratio belonging to a frequency code
    function automatic logic [RATIO_W-1:0] pci_ratio_of(input logic [FS_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'b1111, 4'b1110, 4'b1101,
            4'b0111, 4'b0110, 4'b0101: r = 3'd2;
            4'b0001, 4'b0000:          r = 3'd4;
            default:                   r = 3'd3;
        endcase
        return r;
    endfunction

    // Number of CPU periods the PCI clock stays high: ceil(ratio/2)
    function automatic logic [RATIO_W-1:0] pci_high_of(input logic [RATIO_W-1:0] ratio);
        return (ratio + 3'd1) >> 1;
    endfunction

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
    import fsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] fs_pins_i,
    input  logic            mode_pin_i,
    output logic [FS_W-1:0] fs_o,
    output logic            mode_o,
    output logic            valid_o
);

    typedef struct packed {
        logic            valid;
        logic [FS_W-1:0] fs;
        logic            mode;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.fs    = fs_pins_i;
            st_d.mode  = mode_pin_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fs_o    = st_q.fs;
    assign mode_o  = st_q.mode;
    assign valid_o = st_q.valid;

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(st_q.valid)) |-> ($stable(st_q.fs) && $stable(st_q.mode))); // R2

endmodule

// File: rtl/fsel_src_mux.sv
module fsel_src_mux
    import fsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] strap_code_i,
    input  logic [7:0]      cfg_sel_i,
    input  logic            spread_center_i,
    output logic [FS_W-1:0] req_code_o,
    output logic            hiz_o,
    output logic            spread_en_o,
    output spread_kind_e    spread_kind_o
);

    localparam int HIZ_BIT  = 0;
    localparam int SPR_BIT  = 1;
    localparam int TOP_BIT  = 2;
    localparam int SRC_BIT  = 3;
    localparam int LOW_LSB  = 4;
    localparam int LOW_MSB  = 6;
    localparam int WIDE_BIT = 7;

    typedef struct packed {
        logic         hiz;
        logic         spr_en;
        spread_kind_e kind;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic [FS_W-1:0] sw_code;

    always_comb begin
        sw_code    = {cfg_sel_i[TOP_BIT], cfg_sel_i[LOW_MSB:LOW_LSB]};
        req_code_o = cfg_sel_i[SRC_BIT] ? sw_code : strap_code_i;

        cfg_d        = cfg_q;
        cfg_d.hiz    = cfg_sel_i[HIZ_BIT];
        cfg_d.spr_en = cfg_sel_i[SPR_BIT];
        if (!spread_center_i)       cfg_d.kind = SPR_DOWN_HALF;
        else if (cfg_sel_i[WIDE_BIT]) cfg_d.kind = SPR_CTR_HALF;
        else                        cfg_d.kind = SPR_CTR_QTR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{hiz: 1'b0, spr_en: 1'b0, kind: SPR_CTR_QTR};
        else        cfg_q <= cfg_d;
    end

    assign hiz_o         = cfg_q.hiz;
    assign spread_en_o   = cfg_q.spr_en;
    assign spread_kind_o = cfg_q.kind;

    AST_DOWN_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(spread_center_i) |-> (spread_kind_o == SPR_DOWN_HALF)); // R9

    AST_HIZ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_sel_i[HIZ_BIT]) |-> hiz_o); // R8

endmodule

// File: rtl/fsel_clk_div.sv
module fsel_clk_div
    import fsel_pkg::*;
#(
    parameter int HALF_BASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [FS_W-1:0]    req_code_i,
    output logic [FS_W-1:0]    code_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               cpu_o,
    output logic               pci_o
);

    localparam int CNT_W = $clog2(HALF_BASE + (1 << FS_W));

    typedef struct packed {
        logic               run;
        logic               cpu;
        logic               pci;
        logic [CNT_W-1:0]   cnt;
        logic [RATIO_W-1:0] idx;
        logic [FS_W-1:0]    code;
    } div_st_t;

    div_st_t dv_d, dv_q;
    logic [CNT_W-1:0]   half_cur;
    logic [RATIO_W-1:0] ratio_cur;

    always_comb begin
        half_cur  = CNT_W'(HALF_BASE) + CNT_W'(dv_q.code);
        ratio_cur = pci_ratio_of(dv_q.code);

        dv_d     = dv_q;
        dv_d.run = run_i;
        if (!run_i) begin
            dv_d.cpu  = 1'b0;
            dv_d.pci  = 1'b0;
            dv_d.cnt  = '0;
            dv_d.idx  = '0;
            dv_d.code = req_code_i;
        end else if (!dv_q.run) begin
            // first cycle of operation: open a fresh period on both clocks
            dv_d.cpu  = 1'b1;
            dv_d.pci  = 1'b1;
            dv_d.cnt  = '0;
            dv_d.idx  = '0;
            dv_d.code = req_code_i;
        end else if (dv_q.cnt == half_cur - CNT_W'(1)) begin
            dv_d.cnt = '0;
            dv_d.cpu = ~dv_q.cpu;
            if (!dv_q.cpu) begin
                // CPU period ends here; PCI period may end too
                if (dv_q.idx == ratio_cur - 3'd1) begin
                    dv_d.idx  = '0;
                    dv_d.code = req_code_i;
                end else begin
                    dv_d.idx = dv_q.idx + 3'd1;
                end
                dv_d.pci = (dv_d.idx < pci_high_of(pci_ratio_of(dv_d.code)));
            end
        end else begin
            dv_d.cnt = dv_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign code_o  = dv_q.code;
    assign ratio_o = ratio_cur;
    assign cpu_o   = dv_q.cpu;
    assign pci_o   = dv_q.pci;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.run |-> (dv_q.cnt < half_cur)); // R6

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.run |-> (dv_q.idx < ratio_cur)); // R6

    AST_PCI_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_q.pci) |-> $rose(dv_q.cpu)); // R6

    AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_q.run && $past(dv_q.run) && (dv_q.code != $past(dv_q.code)))
            |-> (dv_q.pci && !$past(dv_q.pci))); // R7

endmodule

// File: rtl/fsel_top.sv
module fsel_top
    import fsel_pkg::*;
#(
    parameter int HALF_BASE = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic [3:0] strap_fs_i,
    input  logic       strap_mode_i,
    input  logic [7:0] cfg_sel_i,
    input  logic       spread_center_i,
    output logic [3:0] freq_code_o,
    output logic [2:0] pci_ratio_o,
    output logic       cpu_clk_o,
    output logic       pci_clk_o,
    output logic       outputs_hiz_o,
    output logic       spread_en_o,
    output logic [1:0] spread_kind_o,
    output logic       pin2_is_stop_o
);

    logic [FS_W-1:0] strap_code;
    logic            strap_mode;
    logic            strap_valid;
    logic [FS_W-1:0] req_code;
    spread_kind_e    kind;

    fsel_strap_latch u_strap (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .fs_pins_i  (strap_fs_i),
        .mode_pin_i (strap_mode_i),
        .fs_o       (strap_code),
        .mode_o     (strap_mode),
        .valid_o    (strap_valid)
    );

    fsel_src_mux u_src (
        .clk             (clk_ref),
        .rst_n           (rst_n),
        .strap_code_i    (strap_code),
        .cfg_sel_i       (cfg_sel_i),
        .spread_center_i (spread_center_i),
        .req_code_o      (req_code),
        .hiz_o           (outputs_hiz_o),
        .spread_en_o     (spread_en_o),
        .spread_kind_o   (kind)
    );

    fsel_clk_div #(.HALF_BASE(HALF_BASE)) u_div (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .run_i      (strap_valid),
        .req_code_i (req_code),
        .code_o     (freq_code_o),
        .ratio_o    (pci_ratio_o),
        .cpu_o      (cpu_clk_o),
        .pci_o      (pci_clk_o)
    );

    assign spread_kind_o  = kind;
    assign pin2_is_stop_o = ~strap_mode;

    AST_CLOCKS_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !strap_valid |-> (!cpu_clk_o && !pci_clk_o)); // R6

endmodule

// File: tb/sim_fsel_top.sv
module sim_fsel_top;

    localparam int HB = 2;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] strap_fs = 4'b0;
    logic       strap_mode = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       center = 1'b1;
    logic [3:0] code;
    logic [2:0] ratio;
    logic       cpu, pci, hiz, spr_en, stop_sel;
    logic [1:0] kind;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    always #10 clk = ~clk;

    fsel_top #(.HALF_BASE(HB)) u0 (
        .clk_ref(clk), .rst_n(rst_n), .strap_fs_i(strap_fs), .strap_mode_i(strap_mode),
        .cfg_sel_i(cfg), .spread_center_i(center), .freq_code_o(code), .pci_ratio_o(ratio),
        .cpu_clk_o(cpu), .pci_clk_o(pci), .outputs_hiz_o(hiz), .spread_en_o(spr_en),
        .spread_kind_o(kind), .pin2_is_stop_o(stop_sel)
    );

    function automatic int exp_ratio(input logic [3:0] c);
        if (c == 4'hF || c == 4'hE || c == 4'hD || c == 4'h7 || c == 4'h6 || c == 4'h5) return 2;
        if (c == 4'h0 || c == 4'h1) return 4;
        return 3;
    endfunction

    function automatic int exp_kind(input logic [7:0] b, input logic ctr);
        if (!ctr) return 2;
        return b[7] ? 1 : 0;
    endfunction

    function automatic logic [3:0] exp_code(input logic [7:0] b, input logic [3:0] straps);
        return b[3] ? {b[2], b[6], b[5], b[4]} : straps;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // continuous clock-shape monitor (R6, R7)
    logic       p_cpu = 1'b0, p_pci = 1'b0;
    logic [3:0] p_code = 4'b0;
    bit ph_valid = 1'b0, pci_valid = 1'b0;
    int ph_len = 0, ph_code = 0, rises = 0, r_at = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            automatic bit c_rise = cpu && !p_cpu;
            automatic bit p_rise = pci && !p_pci;
            automatic bit p_fall = !pci && p_pci;
            if (cpu != p_cpu) begin
                if (ph_valid) check(ph_len == HB + ph_code, "R6 phase length", ph_len, HB + ph_code);
                ph_valid = 1'b1;
                ph_len = 1;
                ph_code = int'(code);
            end else begin
                ph_len++;
            end
            if (p_rise) begin
                check(c_rise, "R6 pci rise with cpu rise", int'(c_rise), 1);
                if (pci_valid) check(rises == r_at - 1, "R6 pci period", rises + 1, r_at);
                pci_valid = 1'b1;
                rises = 0;
                r_at = int'(ratio);
            end else begin
                if (p_fall && pci_valid) begin
                    check(c_rise, "R6 pci fall with cpu rise", int'(c_rise), 1);
                    check(rises == (r_at + 1) / 2 - 1, "R6 pci high time", rises + 1, (r_at + 1) / 2);
                end
                if (c_rise) rises++;
            end
            if (code != p_code) check(p_rise, "R7 code change off boundary", int'(code), int'(p_code));
        end else begin
            ph_valid = 1'b0;
            pci_valid = 1'b0;
        end
        p_cpu = cpu;
        p_pci = pci;
        p_code = code;
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apply_cfg(input logic [7:0] b, input logic ctr, input logic [3:0] straps);
        cfg = b;
        center = ctr;
        wait_neg(1);
        check(hiz == b[0], "R8 hiz", int'(hiz), int'(b[0]));
        check(spr_en == b[1], "R8 spread enable", int'(spr_en), int'(b[1]));
        check(int'(kind) == exp_kind(b, ctr), "R9 spread kind", int'(kind), exp_kind(b, ctr));
        wait_neg(300);
        check(code == exp_code(b, straps), "R4 active code", int'(code), int'(exp_code(b, straps)));
        check(int'(ratio) == exp_ratio(code), "R5 pci ratio", int'(ratio), exp_ratio(code));
    endtask

    initial begin
        void'($urandom(32'h5EED));
        strap_fs = 4'b1010;
        strap_mode = 1'b0;
        wait_neg(3);
        // R1 reset state
        check(!cpu && !pci, "R1 clocks low", int'({cpu, pci}), 0);
        check(!hiz && !spr_en && kind == 2'd0, "R1 config reset", int'({hiz, spr_en, kind}), 0);

        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        strap_fs = 4'b0101;
        strap_mode = 1'b1;
        mon_en = 1'b1;
        wait_neg(2);
        check(stop_sel == 1'b1, "R3 pin role after mode 0", int'(stop_sel), 1);
        wait_neg(300);
        check(code == 4'b1010, "R2 strap held", int'(code), 10);
        check(int'(ratio) == 3, "R5 ratio strap code", int'(ratio), 3);

        for (int i = 0; i < 16; i++) begin
            automatic logic [7:0] b = 8'($urandom);
            automatic logic c = 1'($urandom);
            apply_cfg(b, c, 4'b1010);
        end

        // directed corners: fastest, ratio-4, slowest, ratio-3 and back to straps
        apply_cfg(8'b0000_1000, 1'b1, 4'b1010);
        apply_cfg(8'b0001_1000, 1'b0, 4'b1010);
        apply_cfg(8'b1111_1111, 1'b1, 4'b1010);
        apply_cfg(8'b0100_1000, 1'b1, 4'b1010);
        apply_cfg(8'b1110_1110, 1'b0, 4'b1010);
        apply_cfg(8'b0000_0000, 1'b1, 4'b1010);

        // second reset with new strap levels (R2, R3)
        mon_en = 1'b0;
        rst_n = 1'b0;
        strap_fs = 4'b0001;
        strap_mode = 1'b1;
        wait_neg(3);
        check(!cpu && !pci, "R1 clocks low again", int'({cpu, pci}), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        strap_fs = 4'b1111;
        strap_mode = 1'b0;
        mon_en = 1'b1;
        wait_neg(2);
        check(stop_sel == 1'b0, "R3 pin role after mode 1", int'(stop_sel), 0);
        wait_neg(300);
        check(code == 4'b0001, "R2 recapture", int'(code), 1);
        check(int'(ratio) == 4, "R5 ratio code 0001", int'(ratio), 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule